// File: doc/BRIEF.md
# Snapshot-Read Timestamp Counter Pair

This block is a two-stage timestamp counter. A prescale stage counts counter-clock cycles up to a programmable limit, then returns to zero and advances a wide free-running counter by one. Software reaches both stages and their controls through a small register port: a one-cycle request strobe with a write flag, and read data returned on the following cycle with a valid strobe.

The prescale stage is never read directly. A read of the free-running counter returns that counter's value and, in the same clock edge, copies the live prescale count into a snapshot register. The prescale address returns only that snapshot. Software reads the free-running counter first and the prescale address second, and gets a consistent pair that gives the time at the moment of the first read. Writes to either counter address load the live counter, not the snapshot. An enable bit starts and stops both stages.

Top module: `snap_ts_counter`

## Requirements
- R1: After reset the free-running counter, the prescale count, the snapshot, the compare value and the enable bit are all zero, and the read-valid strobe is low.
- R2: While the enable bit is zero, neither the prescale count nor the free-running counter changes.
- R3: While enabled, the prescale count rises by one per clock. In a cycle where it equals the compare value, it returns to zero and the free-running counter rises by one.
- R4: The free-running counter wraps from all ones to zero.
- R5: A read of the free-running counter (address 1) returns the counter's value at the read edge, and at that same edge loads the snapshot with the live prescale count.
- R6: A read of the snapshot address (address 2) returns the snapshot. Repeated reads with no free-running read between them return the same value while the live count moves on.
- R7: The snapshot changes only on a read of address 1. It is not changed by writes, or by reads of addresses 0, 2, 3 or unmapped addresses.
- R8: A write to address 1 loads the free-running counter and a write to address 2 loads the live prescale count. Neither write alters the snapshot.
- R9: Every read yields exactly one cycle of read-valid, one clock after the request. Writes yield none.
- R10: Address 0 holds the enable in bit 0, and address 3 holds the compare value. Both read back what was written. Any other address reads zero.
- R11: A prescale count loaded above the compare value counts on to the top of its width and wraps to zero without advancing the free-running counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-data strobe |

## Verification
The bench builds the block with an 8-bit prescale stage and a 32-bit free-running counter. With the narrow prescale width, a count loaded above the compare value rolls through its whole range in a few hundred cycles, so the R11 path can be observed. The full 32-bit counter wrap is reached by loading the counter near all ones with a compare of zero. Every read result is compared against a reference model that the bench builds from the requirements.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned TSC_CTRL = 0;
  localparam int unsigned TSC_FRC  = 1;
  localparam int unsigned TSC_SNAP = 2;
  localparam int unsigned TSC_CMP  = 3;

  typedef struct packed {
    logic rd_ctrl;
    logic rd_frc;
    logic rd_snap;
    logic rd_cmp;
    logic rd_other;
    logic wr_ctrl;
    logic wr_frc;
    logic wr_uc;
    logic wr_cmp;
  } tsc_acc_t;
endpackage

// File: rtl/tsc_decode.sv
module tsc_decode
  import tsc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output tsc_acc_t          acc
);
  logic is_ctrl, is_frc, is_snap, is_cmp, rd, wr;

  always_comb begin
    is_ctrl = (addr == ADDR_W'(TSC_CTRL));
    is_frc  = (addr == ADDR_W'(TSC_FRC));
    is_snap = (addr == ADDR_W'(TSC_SNAP));
    is_cmp  = (addr == ADDR_W'(TSC_CMP));
    rd      = req && !we;
    wr      = req && we;
    acc.rd_ctrl  = rd && is_ctrl;
    acc.rd_frc   = rd && is_frc;
    acc.rd_snap  = rd && is_snap;
    acc.rd_cmp   = rd && is_cmp;
    acc.rd_other = rd && !(is_ctrl || is_frc || is_snap || is_cmp);
    acc.wr_ctrl  = wr && is_ctrl;
    acc.wr_frc   = wr && is_frc;
    acc.wr_uc    = wr && is_snap;
    acc.wr_cmp   = wr && is_cmp;
  end
endmodule

// File: rtl/tsc_prescale.sv
module tsc_prescale #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ld_uc,
  input  logic             ld_cmp,
  input  logic [PRE_W-1:0] wval,
  output logic [PRE_W-1:0] uc,
  output logic [PRE_W-1:0] cmp,
  output logic             tick
);
  logic at_limit;

  assign at_limit = (uc == cmp);
  assign tick     = en && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      uc  <= '0;
      cmp <= '0;
    end else begin
      if (ld_uc)
        uc <= wval;
      else if (en)
        uc <= at_limit ? '0 : uc + 1'b1;
      if (ld_cmp)
        cmp <= wval;
    end
  end

  a_r3_uc_step: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_uc && uc != cmp) |=> (uc == $past(uc) + 1'b1));
  a_r3_uc_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_uc && uc == cmp) |=> (uc == '0));
  a_r2_uc_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld_uc) |=> $stable(uc));
endmodule

// File: rtl/tsc_freerun.sv
module tsc_freerun #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ld,
  input  logic [DATA_W-1:0] wval,
  output logic [DATA_W-1:0] frc
);
  always_ff @(posedge clk) begin
    if (rst)
      frc <= '0;
    else if (ld)
      frc <= wval;
    else if (tick)
      frc <= frc + 1'b1;
  end

  a_r3_frc_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld) |=> (frc == $past(frc) + 1'b1));
  a_r2_frc_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(frc));
endmodule

// File: rtl/tsc_readport.sv
module tsc_readport
  import tsc_pkg::*;
#(
  parameter int PRE_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  tsc_acc_t          acc,
  input  logic              en,
  input  logic [DATA_W-1:0] frc,
  input  logic [PRE_W-1:0]  uc_live,
  input  logic [PRE_W-1:0]  cmp,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [PRE_W-1:0]  snap;
  logic [DATA_W-1:0] sel;
  logic              any_rd;

  assign any_rd = acc.rd_ctrl | acc.rd_frc | acc.rd_snap | acc.rd_cmp | acc.rd_other;

  always_comb begin
    sel = '0;
    if (acc.rd_ctrl) sel = DATA_W'(en);
    if (acc.rd_frc)  sel = frc;
    if (acc.rd_snap) sel = DATA_W'(snap);
    if (acc.rd_cmp)  sel = DATA_W'(cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap   <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= any_rd;
      if (any_rd)     rdata <= sel;
      if (acc.rd_frc) snap  <= uc_live;
    end
  end

  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    acc.rd_frc |=> (snap == $past(uc_live) && rdata == $past(frc)));
  a_r7_snap_only_on_frc: assert property (@(posedge clk) disable iff (rst)
    !acc.rd_frc |=> $stable(snap));
  a_r6_snap_read: assert property (@(posedge clk) disable iff (rst)
    acc.rd_snap |=> (rdata == DATA_W'($past(snap))));
  a_r9_rvalid_on_read: assert property (@(posedge clk) disable iff (rst)
    any_rd |=> rvalid);
  a_r9_rvalid_quiet: assert property (@(posedge clk) disable iff (rst)
    !any_rd |=> !rvalid);
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    acc.rd_other |=> (rdata == '0));
endmodule

// File: rtl/snap_ts_counter.sv
module snap_ts_counter
  import tsc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  tsc_acc_t         acc;
  logic             en;
  logic             tick;
  logic [PRE_W-1:0] uc, cmp;
  logic [DATA_W-1:0] frc;

  tsc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst)
      en <= 1'b0;
    else if (acc.wr_ctrl)
      en <= bus_wdata[0];
  end

  tsc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(en), .ld_uc(acc.wr_uc), .ld_cmp(acc.wr_cmp),
    .wval(bus_wdata[PRE_W-1:0]), .uc(uc), .cmp(cmp), .tick(tick)
  );

  tsc_freerun #(.DATA_W(DATA_W)) u_frc (
    .clk(clk), .rst(rst), .tick(tick), .ld(acc.wr_frc),
    .wval(bus_wdata), .frc(frc)
  );

  tsc_readport #(.PRE_W(PRE_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .acc(acc), .en(en), .frc(frc), .uc_live(uc),
    .cmp(cmp), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
    !acc.wr_ctrl |=> $stable(en));
endmodule

// File: tb/snap_ts_counter_test.sv
module snap_ts_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 8;

  typedef struct {
    logic [DATA_W-1:0] val;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvalid;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  exp_t sb[$];

  logic [PRE_W-1:0]  m_uc, m_cmp, m_snap;
  logic [DATA_W-1:0] m_frc;
  logic              m_en;
  bit                exp_rv;

  snap_ts_counter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements; pushes expected reads.
  always @(posedge clk) begin
    exp_t e;
    logic              tk;
    logic [PRE_W-1:0]  nuc;
    logic [DATA_W-1:0] nfrc;
    if (rst) begin
      m_uc = '0; m_cmp = '0; m_snap = '0; m_frc = '0; m_en = 1'b0; exp_rv = 1'b0;
    end else begin
      exp_rv = bus_req && !bus_we;
      if (exp_rv) begin
        case (bus_addr)
          4'd0:    e.val = DATA_W'(m_en);
          4'd1:    e.val = m_frc;
          4'd2:    e.val = DATA_W'(m_snap);
          4'd3:    e.val = DATA_W'(m_cmp);
          default: e.val = '0;
        endcase
        e.tag = cur_tag;
        sb.push_back(e);
        if (bus_addr == 4'd1) m_snap = m_uc;
      end
      tk   = m_en && (m_uc == m_cmp);
      nuc  = m_en ? (tk ? '0 : m_uc + 1'b1) : m_uc;
      nfrc = tk ? m_frc + 1'b1 : m_frc;
      if (bus_req && bus_we) begin
        case (bus_addr)
          4'd0: m_en  = bus_wdata[0];
          4'd1: nfrc  = bus_wdata;
          4'd2: nuc   = bus_wdata[PRE_W-1:0];
          4'd3: m_cmp = bus_wdata[PRE_W-1:0];
          default: ;
        endcase
      end
      m_uc  = nuc;
      m_frc = nfrc;
    end
  end

  // Monitor: pops expected reads as read data appears.
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (bus_rvalid !== exp_rv) begin
        errors++;
        $display("FAIL R9 rvalid actual %0b expected %0b", bus_rvalid, exp_rv);
      end
      if (bus_rvalid === 1'b1) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected read data actual %h expected none", bus_rdata);
        end else begin
          e = sb.pop_front();
          if (bus_rdata !== e.val) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", e.tag, bus_rdata, e.val);
          end
        end
      end
    end
  end

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; cur_tag = tag;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", DATA_W'(bus_rvalid), '0);
    check("R1 rdata in reset", bus_rdata, '0);
    rst = 1'b0;
    // R1 / R10: all registers zero after reset, unmapped reads zero
    rd(4'd0, "R1"); rd(4'd1, "R1"); rd(4'd2, "R1"); rd(4'd3, "R1"); rd(4'd7, "R10");
    // R10: write-back of compare and enable
    wr(4'd3, 32'h0000_0003);
    wr(4'd0, 32'h0000_0001);
    rd(4'd3, "R10"); rd(4'd0, "R10");
    // R3 / R5: counting and capture on free-running read
    idle(13);
    rd(4'd1, "R3"); rd(4'd2, "R5");
    // R9: exactly one valid pulse after a read, none after a write
    check("R9 valid after read", DATA_W'(bus_rvalid), 32'd1);
    idle(1);
    check("R9 valid drops", DATA_W'(bus_rvalid), 32'd0);
    // R6: snapshot stays put while live count moves
    idle(5);
    rd(4'd2, "R6"); idle(3); rd(4'd2, "R6");
    // R7: other reads do not touch the snapshot
    rd(4'd0, "R7"); rd(4'd3, "R7"); rd(4'd9, "R7"); rd(4'd2, "R7");
    // R8: counter writes load live values, snapshot untouched
    wr(4'd1, 32'd100);
    check("R9 no valid after write", DATA_W'(bus_rvalid), 32'd0);
    wr(4'd2, 32'd2);
    rd(4'd2, "R8"); rd(4'd1, "R8"); rd(4'd2, "R8");
    // R2: disabled counters hold
    wr(4'd0, 32'd0);
    idle(7); rd(4'd1, "R2"); rd(4'd2, "R2");
    idle(7); rd(4'd1, "R2"); rd(4'd2, "R2");
    // R4: free-running wrap with compare zero
    wr(4'd3, 32'd0); wr(4'd2, 32'd0); wr(4'd1, 32'hFFFF_FFFE);
    wr(4'd0, 32'd1);
    idle(2);
    rd(4'd1, "R4");
    wr(4'd0, 32'd0);
    rd(4'd1, "R4"); rd(4'd2, "R4");
    // R11: count loaded above compare rolls through full width
    wr(4'd3, 32'd10); wr(4'd2, 32'd11); wr(4'd1, 32'd0);
    wr(4'd0, 32'd1);
    idle(200);
    rd(4'd1, "R11"); rd(4'd2, "R11");
    idle(100);
    rd(4'd1, "R11"); rd(4'd2, "R11");
    idle(3);
    check("R9 scoreboard drained", DATA_W'(sb.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule